// File: doc/BRIEF.md
# Branch Target Buffer Next-Fetch-Address Predictor

This block sits in the fetch stage and turns the current program counter into the address to fetch on the following cycle. It keeps a small direct-mapped table. Each entry holds a valid bit, an address tag, the branch target seen on the most recent execution, and a two-bit direction state. A lookup that matches an entry means the fetched word is a branch. If that entry also predicts taken, the stored target becomes the next fetch address. In every other case the next address is the current one plus the instruction size. The lookup path is purely combinational, so the prediction is ready in the same cycle as the program counter.

The execute stage reports each resolved branch through an update port. The report carries the branch address, its actual direction, its computed target, and whether it was mispredicted. The `mode_hyst` input chooses how the direction state learns:
- **Last-outcome mode**: the state simply follows the latest outcome.
- **Hysteresis mode**: the state is a saturating four-state counter.

Three saturating counters expose how many lookups were made, how many of them hit, and how many mispredictions were reported.

The direction state is an enumerated machine. Its states are DIR_STRONG_NT (encoding 00), DIR_WEAK_NT (01), DIR_WEAK_T (10) and DIR_STRONG_T (11). The prediction is the upper bit of the state.

In hysteresis mode the transitions are:
- on a taken outcome: STRONG_NT to WEAK_NT, WEAK_NT to WEAK_T, WEAK_T to STRONG_T, and STRONG_T stays where it is;
- on a not-taken outcome: STRONG_T to WEAK_T, WEAK_T to WEAK_NT, WEAK_NT to STRONG_NT, and STRONG_NT stays where it is.

In last-outcome mode the transitions are:
- a taken outcome moves any state to STRONG_T;
- a not-taken outcome moves any state to STRONG_NT.

A new entry starts from WEAK_T, and the outcome that allocated it is then applied to that starting state.

Top module: `btb_nfa_predictor`

## Requirements
- R1: With 4-byte instructions and 16 entries, the entry index is pc[5:2] and the tag is pc[31:6]. A lookup hits only when the indexed entry is valid, its tag equals the upper bits, and pc[1:0] is zero. Addresses that share an index but differ in tag miss.
- R2: `next_pc` equals the stored target when the lookup hits and the state's upper bit is 1. Otherwise `next_pc` equals `fetch_pc` + 4.
- R3: A taken update that misses allocates the entry, writing its tag and target. A not-taken update that misses changes nothing, and the entry already at that index keeps hitting.
- R4: A taken update that hits replaces the stored target with the newly reported one. A not-taken update that hits keeps the stored target.
- R5: In last-outcome mode (`mode_hyst`=0), an update moves the state to STRONG_T on taken and to STRONG_NT on not-taken. The next prediction therefore equals the last outcome.
- R6: In hysteresis mode (`mode_hyst`=1), the state is a counter that saturates at both ends. A strong state does not change its prediction after a single opposite outcome.
- R7: A newly allocated entry starts at WEAK_T, and the allocating outcome is applied to it. Strictly alternating outcomes that follow the allocation are therefore predicted correctly exactly half of the time.
- R8: For a loop branch of 4 iterations, on its second visit, last-outcome mode mispredicts the first and the last iteration. Hysteresis mode mispredicts only the exit iteration.
- R9: When an update and a lookup hit the same index in one cycle, the lookup sees the entry as it was before the update. The update becomes visible on the next cycle.
- R10: `cnt_lookup`, `cnt_hit` and `cnt_mispred` count valid lookups, valid lookups that hit, and updates flagged as mispredicted. Each saturates at 255.
- R11: After reset every entry is invalid, so any lookup misses and predicts `fetch_pc` + 4. All three counters read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_hyst | input | 1 | 1 selects the hysteresis counter, 0 selects last-outcome |
| fetch_valid | input | 1 | A lookup is presented this cycle (gates the counters) |
| fetch_pc | input | 32 | Current fetch address |
| pred_hit | output | 1 | The lookup matched a valid entry |
| pred_taken | output | 1 | The matching entry predicts taken |
| next_pc | output | 32 | Predicted next fetch address |
| upd_valid | input | 1 | A resolved branch is reported this cycle |
| upd_pc | input | 32 | Address of the resolved branch |
| upd_taken | input | 1 | Actual direction of the resolved branch |
| upd_target | input | 32 | Computed target of the resolved branch |
| upd_mispred | input | 1 | The resolved branch had been mispredicted |
| cnt_lookup | output | 8 | Saturating count of lookups |
| cnt_hit | output | 8 | Saturating count of lookup hits |
| cnt_mispred | output | 8 | Saturating count of reported mispredictions |

## Verification
A corrupted direction state shows up at `next_pc` on the very next lookup of that branch. It therefore surfaces one cycle after the faulty update, as a wrong choice between the target and the sequential address. A wrong tag or valid bit shows up as `pred_hit` asserting for an alias, or dropping for a known branch, on that same next lookup. A wrong hysteresis transition may stay hidden until a second outcome arrives. For that reason the loop and alternating-outcome sequences count mispredictions per visit, and these counts reveal a state that flips one step too early.

// File: rtl/btb_pkg.sv
package btb_pkg;
    typedef enum logic [1:0] {
        DIR_STRONG_NT = 2'b00,
        DIR_WEAK_NT   = 2'b01,
        DIR_WEAK_T    = 2'b10,
        DIR_STRONG_T  = 2'b11
    } dir_state_e;
endpackage

// File: rtl/btb_dir_next.sv
module btb_dir_next
    import btb_pkg::*;
(
    input  logic       mode_hyst,
    input  dir_state_e cur,
    input  logic       taken,
    output dir_state_e nxt
);
    always_comb begin
        nxt = cur;
        if (!mode_hyst) begin
            nxt = taken ? DIR_STRONG_T : DIR_STRONG_NT;
        end else begin
            unique case (cur)
                DIR_STRONG_NT: nxt = taken ? DIR_WEAK_NT  : DIR_STRONG_NT;
                DIR_WEAK_NT:   nxt = taken ? DIR_WEAK_T   : DIR_STRONG_NT;
                DIR_WEAK_T:    nxt = taken ? DIR_STRONG_T : DIR_WEAK_NT;
                DIR_STRONG_T:  nxt = taken ? DIR_STRONG_T : DIR_WEAK_T;
                default:       nxt = DIR_WEAK_T;
            endcase
        end
    end
endmodule

// File: rtl/btb_table.sv
module btb_table
    import btb_pkg::*;
#(
    parameter int PC_W  = 32,
    parameter int IDX_W = 4,
    parameter int OFF   = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            mode_hyst,
    input  logic [PC_W-1:0] rd_pc,
    output logic            rd_hit,
    output logic            rd_taken,
    output logic [PC_W-1:0] rd_target,
    input  logic            wr_en,
    input  logic [PC_W-1:0] wr_pc,
    input  logic            wr_taken,
    input  logic [PC_W-1:0] wr_target
);
    localparam int N     = 1 << IDX_W;
    localparam int TAG_W = PC_W - IDX_W - OFF;

    logic [N-1:0]     valid_q;
    logic [TAG_W-1:0] tag_q [N];
    logic [PC_W-1:0]  tgt_q [N];
    dir_state_e       st_q  [N];

    logic [IDX_W-1:0] rd_idx, wr_idx;
    logic [TAG_W-1:0] rd_tag, wr_tag;
    logic             rd_aligned, wr_aligned, wr_hit;
    dir_state_e       wr_cur, wr_nxt;

    assign rd_idx     = rd_pc[OFF +: IDX_W];
    assign rd_tag     = rd_pc[PC_W-1 -: TAG_W];
    assign rd_aligned = (rd_pc[OFF-1:0] == '0);
    assign rd_hit     = valid_q[rd_idx] && (tag_q[rd_idx] == rd_tag) && rd_aligned;
    assign rd_taken   = rd_hit && st_q[rd_idx][1];
    assign rd_target  = tgt_q[rd_idx];

    assign wr_idx     = wr_pc[OFF +: IDX_W];
    assign wr_tag     = wr_pc[PC_W-1 -: TAG_W];
    assign wr_aligned = (wr_pc[OFF-1:0] == '0);
    assign wr_hit     = valid_q[wr_idx] && (tag_q[wr_idx] == wr_tag) && wr_aligned;
    assign wr_cur     = wr_hit ? st_q[wr_idx] : DIR_WEAK_T;

    btb_dir_next u_next (
        .mode_hyst (mode_hyst),
        .cur       (wr_cur),
        .taken     (wr_taken),
        .nxt       (wr_nxt)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= '0;
            for (int i = 0; i < N; i++) begin
                tag_q[i] <= '0;
                tgt_q[i] <= '0;
                st_q[i]  <= DIR_WEAK_T;
            end
        end else if (wr_en && wr_aligned) begin
            if (wr_hit) begin
                st_q[wr_idx] <= wr_nxt;
                if (wr_taken) tgt_q[wr_idx] <= wr_target;
            end else if (wr_taken) begin
                valid_q[wr_idx] <= 1'b1;
                tag_q[wr_idx]   <= wr_tag;
                tgt_q[wr_idx]   <= wr_target;
                st_q[wr_idx]    <= wr_nxt;
            end
        end
    end

    p_nt_miss_no_alloc_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_hit && !wr_taken) |=> (valid_q == $past(valid_q)));

    p_taken_alloc_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_aligned && wr_taken) |=> valid_q[$past(wr_idx)]);

    p_strong_t_holds_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_hit && mode_hyst && !wr_taken && st_q[wr_idx] == DIR_STRONG_T)
        |=> st_q[$past(wr_idx)][1]);

    p_strong_nt_holds_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_hit && mode_hyst && wr_taken && st_q[wr_idx] == DIR_STRONG_NT)
        |=> !st_q[$past(wr_idx)][1]);

    p_last_outcome_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_aligned && (wr_hit || wr_taken) && !mode_hyst)
        |=> (st_q[$past(wr_idx)][1] == $past(wr_taken)));
endmodule

// File: rtl/btb_sat_cnt.sv
module btb_sat_cnt #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         inc,
    output logic [W-1:0] cnt
);
    localparam logic [W-1:0] MAX = '1;

    always_ff @(posedge clk) begin
        if (!rst_n)                 cnt <= '0;
        else if (inc && cnt != MAX) cnt <= cnt + 1'b1;
    end

    p_sat_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt == MAX) |=> (cnt == MAX));

    p_no_decrease_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !inc |=> (cnt == $past(cnt)));
endmodule

// File: rtl/btb_nfa_predictor.sv
module btb_nfa_predictor #(
    parameter int PC_W       = 32,
    parameter int IDX_W      = 4,
    parameter int INST_BYTES = 4,
    parameter int CNT_W      = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             mode_hyst,
    input  logic             fetch_valid,
    input  logic [PC_W-1:0]  fetch_pc,
    output logic             pred_hit,
    output logic             pred_taken,
    output logic [PC_W-1:0]  next_pc,
    input  logic             upd_valid,
    input  logic [PC_W-1:0]  upd_pc,
    input  logic             upd_taken,
    input  logic [PC_W-1:0]  upd_target,
    input  logic             upd_mispred,
    output logic [CNT_W-1:0] cnt_lookup,
    output logic [CNT_W-1:0] cnt_hit,
    output logic [CNT_W-1:0] cnt_mispred
);
    localparam int NUM_CNT = 3;
    localparam int OFF     = $clog2(INST_BYTES);
    localparam logic [CNT_W-1:0] CMAX = '1;

    logic [PC_W-1:0]  stored_target;
    logic [NUM_CNT-1:0] inc_vec;
    logic [CNT_W-1:0] cnt_arr [NUM_CNT];

    btb_table #(.PC_W(PC_W), .IDX_W(IDX_W), .OFF(OFF)) u_table (
        .clk       (clk),
        .rst_n     (rst_n),
        .mode_hyst (mode_hyst),
        .rd_pc     (fetch_pc),
        .rd_hit    (pred_hit),
        .rd_taken  (pred_taken),
        .rd_target (stored_target),
        .wr_en     (upd_valid),
        .wr_pc     (upd_pc),
        .wr_taken  (upd_taken),
        .wr_target (upd_target)
    );

    assign next_pc = pred_taken ? stored_target : fetch_pc + PC_W'(INST_BYTES);

    assign inc_vec = {upd_valid && upd_mispred, fetch_valid && pred_hit, fetch_valid};

    for (genvar g = 0; g < NUM_CNT; g++) begin : g_cnt
        btb_sat_cnt #(.W(CNT_W)) u_cnt (
            .clk   (clk),
            .rst_n (rst_n),
            .inc   (inc_vec[g]),
            .cnt   (cnt_arr[g])
        );
    end

    assign cnt_lookup  = cnt_arr[0];
    assign cnt_hit     = cnt_arr[1];
    assign cnt_mispred = cnt_arr[2];

    p_hit_count_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_valid && pred_hit && cnt_hit != CMAX) |=> (cnt_hit == $past(cnt_hit) + 1'b1));
endmodule

// File: tb/btb_nfa_predictor_tb.sv
module btb_nfa_predictor_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        mode_hyst = 1'b1;
    logic        fetch_valid = 1'b0;
    logic [31:0] fetch_pc = '0;
    logic        pred_hit, pred_taken;
    logic [31:0] next_pc;
    logic        upd_valid = 1'b0;
    logic [31:0] upd_pc = '0;
    logic        upd_taken = 1'b0;
    logic [31:0] upd_target = '0;
    logic        upd_mispred = 1'b0;
    logic [7:0]  cnt_lookup, cnt_hit, cnt_mispred;

    int checks = 0;
    int errors = 0;
    logic last_pred = 1'b0;

    typedef struct {
        logic [31:0] exp_next;
        logic        exp_hit;
        string       req;
    } exp_t;
    exp_t sb_q[$];

    always #5 clk = ~clk;

    btb_nfa_predictor u_dut (
        .clk(clk), .rst_n(rst_n), .mode_hyst(mode_hyst),
        .fetch_valid(fetch_valid), .fetch_pc(fetch_pc),
        .pred_hit(pred_hit), .pred_taken(pred_taken), .next_pc(next_pc),
        .upd_valid(upd_valid), .upd_pc(upd_pc), .upd_taken(upd_taken),
        .upd_target(upd_target), .upd_mispred(upd_mispred),
        .cnt_lookup(cnt_lookup), .cnt_hit(cnt_hit), .cnt_mispred(cnt_mispred)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // monitor: pops one expectation per valid lookup, away from the edge
    always @(negedge clk) begin
        if (fetch_valid && sb_q.size() > 0) begin
            exp_t e;
            e = sb_q.pop_front();
            last_pred = pred_taken;
            check(pred_hit == e.exp_hit, e.req, "hit", pred_hit, e.exp_hit);
            check(next_pc == e.exp_next, e.req, "next_pc", next_pc, e.exp_next);
        end
    end

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (2) @(posedge clk);
        #1 rst_n = 1'b1;
    endtask

    task automatic lookup(input logic [31:0] pc, input logic hit,
                          input logic [31:0] nxt, input string req);
        exp_t e;
        e.exp_next = nxt; e.exp_hit = hit; e.req = req;
        sb_q.push_back(e);
        fetch_pc = pc; fetch_valid = 1'b1;
        @(posedge clk);
        #1 fetch_valid = 1'b0;
    endtask

    task automatic update(input logic [31:0] pc, input logic tk,
                          input logic [31:0] tgt, input logic mis);
        upd_pc = pc; upd_taken = tk; upd_target = tgt; upd_mispred = mis; upd_valid = 1'b1;
        @(posedge clk);
        #1 upd_valid = 1'b0; upd_mispred = 1'b0;
    endtask

    task automatic exec_branch(input logic [31:0] pc, input logic [31:0] tgt, input logic tk,
                               input logic exp_hit, input logic exp_pred, input string req,
                               output logic mis);
        lookup(pc, exp_hit, exp_pred ? tgt : pc + 32'd4, req);
        mis = (last_pred != tk);
        update(pc, tk, tgt, mis);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual hung expected done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic mis;
        int miss_v2, correct, cnt0;
        do_reset();

        // R11 reset state
        @(negedge clk);
        check(cnt_lookup == 0 && cnt_hit == 0 && cnt_mispred == 0, "R11", "counters",
              {cnt_lookup, cnt_hit, cnt_mispred}, 0);
        @(posedge clk); #1;
        lookup(32'h100, 1'b0, 32'h104, "R11");

        // R3 R2 allocate on taken miss, R1 alias misses
        update(32'h100, 1'b1, 32'h040, 1'b1);
        lookup(32'h100, 1'b1, 32'h040, "R2");
        lookup(32'h140, 1'b0, 32'h144, "R1");
        lookup(32'h102, 1'b0, 32'h106, "R1");
        update(32'h200, 1'b0, 32'h2c0, 1'b0);
        lookup(32'h200, 1'b0, 32'h204, "R3");
        lookup(32'h100, 1'b1, 32'h040, "R3");

        // R4 target refresh and keep
        update(32'h100, 1'b1, 32'h080, 1'b1);
        lookup(32'h100, 1'b1, 32'h080, "R4");
        update(32'h100, 1'b0, 32'h0c0, 1'b1);   // STRONG_T -> WEAK_T
        lookup(32'h100, 1'b1, 32'h080, "R4");

        // R6 hysteresis walk
        update(32'h100, 1'b0, 32'h0c0, 1'b1);   // -> WEAK_NT
        lookup(32'h100, 1'b1, 32'h104, "R6");
        update(32'h100, 1'b0, 32'h0c0, 1'b0);   // -> STRONG_NT
        update(32'h100, 1'b0, 32'h0c0, 1'b0);   // saturates
        update(32'h100, 1'b1, 32'h080, 1'b1);   // -> WEAK_NT
        lookup(32'h100, 1'b1, 32'h104, "R6");
        update(32'h100, 1'b1, 32'h080, 1'b1);   // -> WEAK_T
        lookup(32'h100, 1'b1, 32'h080, "R6");

        // R5 last-outcome mode
        mode_hyst = 1'b0;
        update(32'h100, 1'b0, 32'h080, 1'b1);
        lookup(32'h100, 1'b1, 32'h104, "R5");
        update(32'h100, 1'b1, 32'h080, 1'b1);
        lookup(32'h100, 1'b1, 32'h080, "R5");

        // R9 same-cycle update and lookup
        begin
            exp_t e;
            e.exp_next = 32'h080; e.exp_hit = 1'b1; e.req = "R9";
            sb_q.push_back(e);
            fetch_pc = 32'h100; fetch_valid = 1'b1;
            upd_pc = 32'h100; upd_taken = 1'b0; upd_target = 32'h080; upd_valid = 1'b1;
            @(posedge clk);
            #1 fetch_valid = 1'b0; upd_valid = 1'b0;
        end
        lookup(32'h100, 1'b1, 32'h104, "R9");

        // R8 loop, last-outcome mode
        miss_v2 = 0;
        for (int v = 0; v < 2; v++)
            for (int i = 0; i < 4; i++) begin
                exec_branch(32'h408, 32'h3f0, i != 3, !(v == 0 && i == 0), i != 0, "R8", mis);
                if (v == 1 && mis) miss_v2++;
            end
        check(miss_v2 == 2, "R8", "last-outcome visit-2 mispredicts", miss_v2, 2);

        // R8 loop, hysteresis mode
        mode_hyst = 1'b1;
        miss_v2 = 0;
        for (int v = 0; v < 2; v++)
            for (int i = 0; i < 4; i++) begin
                exec_branch(32'h50c, 32'h4f0, i != 3, !(v == 0 && i == 0),
                            !(v == 0 && i == 0), "R8", mis);
                if (v == 1 && mis) miss_v2++;
            end
        check(miss_v2 == 1, "R8", "hysteresis visit-2 mispredicts", miss_v2, 1);

        // R7 alternating outcomes after allocation
        exec_branch(32'h610, 32'h5c0, 1'b1, 1'b0, 1'b0, "R7", mis);
        correct = 0;
        for (int k = 0; k < 8; k++) begin
            exec_branch(32'h610, 32'h5c0, (k % 2) == 1, 1'b1, 1'b1, "R7", mis);
            if (!mis) correct++;
        end
        check(correct == 4, "R7", "alternating correct", correct, 4);

        // R10 counters
        do_reset();
        update(32'h000, 1'b0, 32'h0, 1'b1);
        update(32'h000, 1'b0, 32'h0, 1'b1);
        update(32'h000, 1'b0, 32'h0, 1'b0);
        @(negedge clk);
        check(cnt_mispred == 2, "R10", "mispred count", cnt_mispred, 2);
        @(posedge clk); #1;
        update(32'h700, 1'b1, 32'h680, 1'b0);
        lookup(32'h700, 1'b1, 32'h680, "R10");
        @(negedge clk);
        cnt0 = cnt_hit;
        check(cnt_hit == 1 && cnt_lookup == 1, "R10", "hit/lookup count",
              {cnt_hit, cnt_lookup}, 16'h0101);
        @(posedge clk); #1;
        for (int n = 0; n < 260; n++) lookup(32'h004, 1'b0, 32'h008, "R10");
        @(negedge clk);
        check(cnt_lookup == 8'd255, "R10", "lookup saturates", cnt_lookup, 255);
        check(cnt_hit == cnt0, "R10", "hit unchanged on misses", cnt_hit, cnt0);
        check(sb_q.size() == 0, "R2", "scoreboard drained", sb_q.size(), 0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule